// File: doc/BRIEF.md
# Autoscan A/D Trigger Sequencer

This block decides when an analog-to-digital converter starts a conversion and which input channel that conversion uses. Software configures it through a small byte-wide register port: a mode register picks the start source and turns channel stepping on or off, a channel register names either a fixed channel or the top of a scan, and a gain register holds the front-end range code. A conversion can be started by a software strobe write, by a tick from an external pacer counter, or by a rising edge on an asynchronous trigger pin. Every accepted request produces one start pulse together with a channel number.

When scanning is enabled, successive conversions walk upward from channel 0 to the programmed top channel and then return to 0. When scanning is off, every conversion uses the programmed channel. The converter reports that it is busy. A request that arrives while the converter is busy, or one cycle after a start, is discarded and recorded in a sticky flag that software can clear.

Top module: `adc_trigger_sequencer`

## Requirements
- R1: After reset the mode register reads 0 (software start, scanning off, pretrigger off), the gain code is 0, the missed flag is 0, `adc_start` is low and `adc_chan` is 0.
- R2: A write to address 0 stores `reg_wdata[3:0]` as the mode. A read of address 0 returns the mode in bits 3:0 and zeros in bits 7:4. Read data appears on `reg_rdata` one clock after the address is presented.
- R3: With mode bits 2 and 1 both clear, a write of any value to address 3 gives exactly one `adc_start` pulse, and pacer ticks and trigger-pin edges start nothing.
- R4: With mode bit 1 set and bit 2 clear, each one-cycle `pacer_tick` gives one start pulse, and strobe writes and pin edges start nothing.
- R5: With mode bit 2 set, each rising edge on `ext_trig` gives one start pulse whatever the value of bit 1. A level held high gives no further starts, and pacer ticks and strobe writes start nothing.
- R6: With mode bit 0 set, successive starts carry channels 0, 1, ... up to the channel register value and then wrap back to 0. This includes a top value of NUM_CH-1.
- R7: With mode bit 0 clear, every start carries the value written to the channel register (address 1, low bits).
- R8: Any write to the channel register returns the scan position to channel 0.
- R9: A write to address 2 stores `reg_wdata[2:0]` as the gain code. The gain code drives `adc_range` and reads back in bits 2:0 of address 2.
- R10: Bit 7 of a read of address 2 reports `adc_busy` as it was when the address was sampled.
- R11: A request that arrives while `adc_busy` is high, or in the cycle after a start, produces no start and sets the missed flag (bit 6 of address 2). The flag stays set until a write to address 2 with `reg_wdata[6]` set. Accepted starts never occur in two consecutive cycles.
- R12: Mode bit 3 (pretrigger enable) drives `pretrig_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 channel, 2 gain/status, 3 strobe) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pacer_tick | input | 1 | One-cycle tick from the pacer counter |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| adc_busy | input | 1 | Converter busy |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_chan | output | CH_W | Channel for the conversion being started |
| adc_range | output | 3 | Front-end gain code |
| pretrig_en | output | 1 | Pretrigger enable level |

## Verification
The bench builds the sequencer with NUM_CH set to 8, so the channel field is three bits wide. Scans to the top channel and the wrap from 7 back to 0 then take only a few strobes. SYNC_STAGES stays at 2, so a pin edge reaches a start within a few cycles and the bench can wait a fixed window for it. Because every source is selectable at run time, each scenario tries the two sources that are not selected as well as the one that is.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_CHAN   = 2'd1;
  localparam logic [1:0] ADDR_GAIN   = 2'd2;
  localparam logic [1:0] ADDR_STROBE = 2'd3;
  localparam int         CLR_BIT     = 6;

  typedef struct packed {
    logic pretrig;
    logic ext_sel;
    logic pacer_sel;
    logic autoscan;
  } mode_t;
endpackage

// File: rtl/seq_ext_sync.sv
module seq_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) sync_q <= rst ? 1'b0 : pin;
    end else begin : g_many
      always_ff @(posedge clk) sync_q <= rst ? '0 : {sync_q[STAGES-2:0], pin};
    end
  endgenerate

  always_ff @(posedge clk) prev_q <= rst ? 1'b0 : sync_q[STAGES-1];

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/seq_trig_select.sv
module seq_trig_select
  import seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t mode,
  input  logic  sw_strobe,
  input  logic  pacer_tick,
  input  logic  ext_rise,
  input  logic  adc_busy,
  input  logic  missed_clr,
  output logic  fire,
  output logic  start_q,
  output logic  missed_q
);
  logic req, blocked;

  always_comb begin
    if (mode.ext_sel)        req = ext_rise;
    else if (mode.pacer_sel) req = pacer_tick;
    else                     req = sw_strobe;
  end

  assign blocked = adc_busy | start_q;
  assign fire    = req & ~blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= 1'b0;
      missed_q <= 1'b0;
    end else begin
      start_q <= fire;
      if (req && blocked) missed_q <= 1'b1;
      else if (missed_clr) missed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/seq_chan_step.sv
module seq_chan_step #(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic            autoscan,
  input  logic [CH_W-1:0] chan_cfg,
  input  logic            ptr_clr,
  output logic [CH_W-1:0] chan_q
);
  logic [CH_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      chan_q <= '0;
    end else begin
      if (ptr_clr)
        ptr_q <= '0;
      else if (fire && autoscan)
        ptr_q <= (ptr_q >= chan_cfg) ? '0 : ptr_q + 1'b1;
      if (fire)
        chan_q <= autoscan ? ptr_q : chan_cfg;
    end
  end
endmodule

// File: rtl/adc_trigger_sequencer.sv
module adc_trigger_sequencer
  import seq_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RANGE_W     = 3,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               pacer_tick,
  input  logic               ext_trig,
  input  logic               adc_busy,
  output logic               adc_start,
  output logic [CH_W-1:0]    adc_chan,
  output logic [RANGE_W-1:0] adc_range,
  output logic               pretrig_en
);
  mode_t             mode_q;
  logic [CH_W-1:0]   chan_cfg;
  logic [RANGE_W-1:0] range_q;
  logic              ext_rise, fire, missed_q;
  logic              wr_mode, wr_chan, wr_gain, wr_strobe;

  assign wr_mode   = reg_wr && reg_addr == ADDR_MODE;
  assign wr_chan   = reg_wr && reg_addr == ADDR_CHAN;
  assign wr_gain   = reg_wr && reg_addr == ADDR_GAIN;
  assign wr_strobe = reg_wr && reg_addr == ADDR_STROBE;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      chan_cfg <= '0;
      range_q  <= '0;
    end else begin
      if (wr_mode) mode_q   <= mode_t'(reg_wdata[3:0]);
      if (wr_chan) chan_cfg <= reg_wdata[CH_W-1:0];
      if (wr_gain) range_q  <= reg_wdata[RANGE_W-1:0];
    end
  end

  seq_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_trig), .rise(ext_rise)
  );

  seq_trig_select u_sel (
    .clk(clk), .rst(rst), .mode(mode_q), .sw_strobe(wr_strobe),
    .pacer_tick(pacer_tick), .ext_rise(ext_rise), .adc_busy(adc_busy),
    .missed_clr(wr_gain && reg_wdata[CLR_BIT]), .fire(fire),
    .start_q(adc_start), .missed_q(missed_q)
  );

  seq_chan_step #(.CH_W(CH_W)) u_step (
    .clk(clk), .rst(rst), .fire(fire), .autoscan(mode_q.autoscan),
    .chan_cfg(chan_cfg), .ptr_clr(wr_chan), .chan_q(adc_chan)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        ADDR_MODE: reg_rdata <= {4'b0000, mode_q};
        ADDR_CHAN: reg_rdata <= 8'(chan_cfg);
        ADDR_GAIN: reg_rdata <= {adc_busy, missed_q, (6 - RANGE_W)'(0), range_q};
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assign adc_range  = range_q;
  assign pretrig_en = mode_q.pretrig;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_wr,
  input logic [1:0]      reg_addr,
  input logic [7:0]      reg_wdata,
  input logic [7:0]      reg_rdata,
  input logic            adc_busy,
  input logic            adc_start,
  input logic [CH_W-1:0] adc_chan,
  input logic [3:0]      mode,
  input logic [CH_W-1:0] chan_cfg,
  input logic            missed
);
  logic armed;
  always_ff @(posedge clk) armed <= rst ? 1'b0 : 1'b1;

  assert_no_double_start_R11: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

  assert_no_start_when_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (armed && adc_start) |-> !$past(adc_busy));

  assert_missed_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(missed) && !$past(reg_wr && reg_addr == 2'd2 && reg_wdata[6]))
      |-> missed);

  assert_scan_in_bounds_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && adc_start && $past(mode[0])) |-> adc_chan <= $past(chan_cfg));

  assert_busy_readback_R10: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(reg_addr) == 2'd2) |-> reg_rdata[7] == $past(adc_busy));

  assert_mode_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(reg_addr) == 2'd0) |-> reg_rdata[7:4] == 4'b0000);
endmodule

bind adc_trigger_sequencer seq_checker #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_busy(adc_busy),
  .adc_start(adc_start), .adc_chan(adc_chan), .mode(mode_q),
  .chan_cfg(chan_cfg), .missed(missed_q)
);

// File: tb/sim_adc_trigger_sequencer.sv
`timescale 1ns/1ps
module sim_adc_trigger_sequencer;
  localparam int NCH = 8;
  localparam int CW  = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, pacer_tick = 0, ext_trig = 0, adc_busy = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic adc_start, pretrig_en;
  logic [CW-1:0] adc_chan;
  logic [2:0] adc_range;

  int n_checks = 0, n_fail = 0, n_starts = 0;
  logic [CW-1:0] chan_log [0:63];
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_trigger_sequencer #(.NUM_CH(NCH), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pacer_tick(pacer_tick),
    .ext_trig(ext_trig), .adc_busy(adc_busy), .adc_start(adc_start),
    .adc_chan(adc_chan), .adc_range(adc_range), .pretrig_en(pretrig_en)
  );

  always @(negedge clk) if (!rst && adc_start) begin
    if (n_starts < 64) chan_log[n_starts] = adc_chan;
    n_starts++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk); pacer_tick = 1;
    @(negedge clk); pacer_tick = 0;
    @(negedge clk);
  endtask

  task automatic pulse_pin();
    @(negedge clk); ext_trig = 1;
    repeat (6) @(negedge clk);
    ext_trig = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(adc_start == 0, "R1 start", adc_start, 0);
    check(adc_chan == 0, "R1 chan", adc_chan, 0);
    rd(2'd0, d); check(d == 0, "R1 mode", d, 0);
    rd(2'd2, d); check(d[6:0] == 0, "R1 gain/missed", d[6:0], 0);
    check(adc_range == 0, "R1 range", adc_range, 0);
  endtask

  task automatic t_mode_rb();
    logic [7:0] d;
    wr(2'd0, 8'hFA); rd(2'd0, d); check(d == 8'h0A, "R2 readback", d, 8'h0A);
    wr(2'd0, 8'h05); rd(2'd0, d); check(d == 8'h05, "R2 readback", d, 8'h05);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_sw();
    int b;
    wr(2'd0, 8'h00); wr(2'd1, 8'd5);
    b = n_starts; wr(2'd3, 8'h00); @(negedge clk);
    check(n_starts == b + 1, "R3 strobe count", n_starts - b, 1);
    check(chan_log[b] == 5, "R3 chan", chan_log[b], 5);
    b = n_starts; tick(); pulse_pin();
    check(n_starts == b, "R3 other sources ignored", n_starts - b, 0);
  endtask

  task automatic t_pacer();
    int b;
    wr(2'd0, 8'h02);
    b = n_starts; tick(); tick(); tick();
    check(n_starts == b + 3, "R4 tick count", n_starts - b, 3);
    b = n_starts; wr(2'd3, 8'h00); pulse_pin();
    check(n_starts == b, "R4 other sources ignored", n_starts - b, 0);
  endtask

  task automatic t_ext();
    int b;
    wr(2'd0, 8'h06);
    b = n_starts; tick(); wr(2'd3, 8'h00); @(negedge clk);
    check(n_starts == b, "R5 other sources ignored", n_starts - b, 0);
    b = n_starts; pulse_pin();
    check(n_starts == b + 1, "R5 edge bit1 set", n_starts - b, 1);
    wr(2'd0, 8'h04);
    b = n_starts; pulse_pin(); pulse_pin();
    check(n_starts == b + 2, "R5 edge bit1 clear", n_starts - b, 2);
  endtask

  task automatic t_autoscan();
    int b;
    wr(2'd0, 8'h01); wr(2'd1, 8'd2);
    b = n_starts;
    for (int i = 0; i < 7; i++) wr(2'd3, 8'h00);
    @(negedge clk);
    check(n_starts == b + 7, "R6 count", n_starts - b, 7);
    for (int i = 0; i < 7; i++)
      check(chan_log[b + i] == i % 3, "R6 scan order", chan_log[b + i], i % 3);
    wr(2'd1, 8'd7);
    b = n_starts;
    for (int i = 0; i < 9; i++) wr(2'd3, 8'h00);
    @(negedge clk);
    for (int i = 0; i < 9; i++)
      check(chan_log[b + i] == i % 8, "R6 full wrap", chan_log[b + i], i % 8);
  endtask

  task automatic t_single();
    int b;
    wr(2'd0, 8'h00); wr(2'd1, 8'd3);
    b = n_starts;
    for (int i = 0; i < 3; i++) wr(2'd3, 8'h00);
    @(negedge clk);
    for (int i = 0; i < 3; i++)
      check(chan_log[b + i] == 3, "R7 fixed chan", chan_log[b + i], 3);
  endtask

  task automatic t_ptr_reset();
    int b;
    wr(2'd0, 8'h01); wr(2'd1, 8'd4);
    b = n_starts; wr(2'd3, 0); wr(2'd3, 0);
    wr(2'd1, 8'd4); wr(2'd3, 0); @(negedge clk);
    check(chan_log[b + 1] == 1, "R8 pre", chan_log[b + 1], 1);
    check(chan_log[b + 2] == 0, "R8 pointer cleared", chan_log[b + 2], 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_range();
    logic [7:0] d;
    wr(2'd2, 8'h05); rd(2'd2, d);
    check(d[2:0] == 5, "R9 readback", d[2:0], 5);
    check(adc_range == 5, "R9 output", adc_range, 5);
    wr(2'd2, 8'hBB); rd(2'd2, d);
    check(d[2:0] == 3, "R9 mask", d[2:0], 3);
  endtask

  task automatic t_busy();
    logic [7:0] d;
    adc_busy = 1; rd(2'd2, d); check(d[7] == 1, "R10 busy high", d[7], 1);
    adc_busy = 0; rd(2'd2, d); check(d[7] == 0, "R10 busy low", d[7], 0);
  endtask

  task automatic t_miss();
    logic [7:0] d;
    int b;
    wr(2'd0, 8'h00); wr(2'd2, 8'h40);
    rd(2'd2, d); check(d[6] == 0, "R11 cleared", d[6], 0);
    adc_busy = 1; b = n_starts; wr(2'd3, 0); @(negedge clk);
    check(n_starts == b, "R11 dropped when busy", n_starts - b, 0);
    adc_busy = 0;
    rd(2'd2, d); check(d[6] == 1, "R11 flag set", d[6], 1);
    b = n_starts; wr(2'd3, 0); @(negedge clk);
    check(n_starts == b + 1, "R11 accepts after busy", n_starts - b, 1);
    rd(2'd2, d); check(d[6] == 1, "R11 sticky", d[6], 1);
    wr(2'd2, 8'h40); rd(2'd2, d); check(d[6] == 0, "R11 clear", d[6], 0);
    b = n_starts;
    @(negedge clk); reg_wr = 1; reg_addr = 2'd3;
    @(negedge clk); @(negedge clk); reg_wr = 0; @(negedge clk);
    check(n_starts == b + 1, "R11 back-to-back", n_starts - b, 1);
    rd(2'd2, d); check(d[6] == 1, "R11 back-to-back flag", d[6], 1);
  endtask

  task automatic t_pretrig();
    wr(2'd0, 8'h08); @(negedge clk);
    check(pretrig_en == 1, "R12 on", pretrig_en, 1);
    wr(2'd0, 8'h00); @(negedge clk);
    check(pretrig_en == 0, "R12 off", pretrig_en, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset(); t_mode_rb(); t_sw(); t_pacer(); t_ext(); t_autoscan();
    t_single(); t_ptr_reset(); t_range(); t_busy(); t_miss(); t_pretrig();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule